// File: doc/BRIEF.md
# Serial EEPROM Identity Reader

This block is a hardware sequencer that fetches a network identity record from a three-wire serial EEPROM. On a single start pulse it selects the memory, clocks out a read command for word address zero, and checks that the memory answers with a leading zero bit. It then clocks in four 16-bit words, most significant bit first. The first three words form the station address and the fourth is a checksum word, which the block passes on without verifying it.

Every change on the three outputs (chip-select, serial clock, data-out) is held for a programmable number of system clocks (`DIV`). A high leading bit ends the transfer at once. The pins go low, an error is latched and the stored words are withheld. A host reads the four words and a two-bit status code. The code keeps "never read or invalid" apart from "read attempted, failed", and the words read as zero unless the last transfer completed.

Top module: `id_eeprom_reader`

## Requirements
- R1: After reset, `ee_cs`, `ee_sck`, `ee_mosi`, `busy`, `done`, `valid` and `err` are low, `status` is 2'b00 and `id_words` is zero.
- R2: `ee_cs` rises while `ee_sck` and `ee_mosi` are both low, and `ee_sck` is never high while `ee_cs` is low.
- R3: The command is nine bits, `1,1,0,0,0,0,0,0,0` in that order. Each bit is placed on `ee_mosi` while `ee_sck` is low and is taken by the following rising edge of `ee_sck`.
- R4: The tenth rising edge of `ee_sck` samples `ee_miso` as the leading bit. If it is high, no further clock edges follow, `ee_cs`/`ee_sck`/`ee_mosi` return low, `err` is set, `valid` stays clear and `status` is 2'b10.
- R5: After a low leading bit, rising edges 11 to 74 each deliver one bit, sampled while `ee_sck` is high. The first bit received is bit 63 of `id_words`, so the first word lands in `id_words[63:48]` and the checksum word in `id_words[15:0]`.
- R6: After the last data bit all three serial outputs are low, `done` pulses for one cycle, `valid` is set and `status` is 2'b01.
- R7: Each change of the output triple {`ee_cs`,`ee_sck`,`ee_mosi`} is held for at least `DIV` system clocks.
- R8: `id_words` reads zero whenever `valid` is low. `valid` and `err` are never both high.
- R9: `busy` is high from the cycle after an accepted `start` until the outputs are back at idle. A `start` pulse while `busy` is high has no effect on the transfer.
- R10: An accepted `start` clears `valid` and `err` immediately, so a previous error or result does not persist into a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| valid | output | 1 | Last transfer completed with a good leading bit |
| err | output | 1 | Last transfer aborted on a high leading bit |
| status | output | 2 | 00 never read or invalid, 01 valid, 10 error |
| id_words | output | 64 | Four received words, first word in the top bits |
| ee_cs | output | 1 | EEPROM chip-select |
| ee_sck | output | 1 | EEPROM serial clock |
| ee_mosi | output | 1 | Serial data to the EEPROM |
| ee_miso | input | 1 | Serial data from the EEPROM |

## Verification
A new `start` request and an ongoing transfer can meet in the same cycle. The bench pulses `start` in the middle of a data burst and again in the cycle where `done` is due. It then judges at the ports: the model counts exactly 74 clock edges, a single `done` pulse appears, and the words match the pattern. The leading-bit abort and the result latch also meet in the final step of a transfer. A model that forces the leading bit high shows that the error path ends after the tenth edge with the pins low and the words withheld.

// File: rtl/id_eeprom_reader.sv
module id_eeprom_reader #(
  parameter int DIV    = 4,
  parameter int WORD_W = 16,
  parameter int NWORDS = 4,
  parameter int ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic                     valid,
  output logic                     err,
  output logic [1:0]               status,
  output logic [WORD_W*NWORDS-1:0] id_words,
  output logic                     ee_cs,
  output logic                     ee_sck,
  output logic                     ee_mosi,
  input  logic                     ee_miso
);

  localparam int CMD_BITS = 3 + ADDR_W;
  localparam int TOTAL    = WORD_W * NWORDS;
  localparam int TW       = $clog2(DIV > 1 ? DIV : 2);
  localparam int CW       = $clog2(TOTAL + 1);
  localparam logic [CMD_BITS-1:0] CMD = {3'b110, {ADDR_W{1'b0}}};

  typedef enum logic [3:0] {
    IDLE, SEL, CMD_LO, CMD_HI, DUM_LO, DUM_HI, DAT_LO, DAT_HI, FIN
  } st_t;

  st_t                 state;
  logic [TW-1:0]       timer;
  logic [CW-1:0]       bcnt;
  logic [CMD_BITS-1:0] cmd_sr;
  logic [TOTAL-1:0]    shreg;
  logic                fail, valid_q, err_q, done_q;

  wire tick = (timer == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      timer   <= '0;
      bcnt    <= '0;
      cmd_sr  <= '0;
      shreg   <= '0;
      fail    <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state == IDLE) begin
        if (start) begin
          state   <= SEL;
          timer   <= TW'(DIV - 1);
          bcnt    <= '0;
          cmd_sr  <= CMD;
          fail    <= 1'b0;
          valid_q <= 1'b0;
          err_q   <= 1'b0;
        end
      end else if (!tick) begin
        timer <= timer - 1'b1;
      end else begin
        timer <= TW'(DIV - 1);
        case (state)
          SEL:    state <= CMD_LO;
          CMD_LO: state <= CMD_HI;
          CMD_HI: begin
            cmd_sr <= cmd_sr << 1;
            if (bcnt == CW'(CMD_BITS - 1)) begin
              state <= DUM_LO;
              bcnt  <= '0;
            end else begin
              state <= CMD_LO;
              bcnt  <= bcnt + 1'b1;
            end
          end
          DUM_LO: state <= DUM_HI;
          DUM_HI: begin
            if (ee_miso) begin
              state <= FIN;
              fail  <= 1'b1;
            end else begin
              state <= DAT_LO;
            end
          end
          DAT_LO: state <= DAT_HI;
          DAT_HI: begin
            shreg <= {shreg[TOTAL-2:0], ee_miso};
            if (bcnt == CW'(TOTAL - 1)) begin
              state <= FIN;
            end else begin
              state <= DAT_LO;
              bcnt  <= bcnt + 1'b1;
            end
          end
          FIN: begin
            state   <= IDLE;
            valid_q <= !fail;
            err_q   <= fail;
            done_q  <= 1'b1;
          end
          default: state <= IDLE;
        endcase
      end
    end
  end

  assign ee_cs    = (state != IDLE) && (state != FIN);
  assign ee_sck   = (state == CMD_HI) || (state == DUM_HI) || (state == DAT_HI);
  assign ee_mosi  = ((state == CMD_LO) || (state == CMD_HI)) && cmd_sr[CMD_BITS-1];
  assign busy     = (state != IDLE);
  assign done     = done_q;
  assign valid    = valid_q;
  assign err      = err_q;
  assign status   = valid_q ? 2'b01 : (err_q ? 2'b10 : 2'b00);
  assign id_words = valid_q ? shreg : '0;

  wire [2:0] pins = {ee_cs, ee_sck, ee_mosi};

  p_sck_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sck |-> ee_cs);

  p_select_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (!ee_sck && !ee_mosi));

  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sck && !ee_mosi && bcnt == '0 && tick && ee_miso && state == DUM_HI)
      |=> (!ee_cs && !ee_sck && !ee_mosi));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ee_cs && !ee_sck && !ee_mosi && !busy));

  p_flags_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && err));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ee_cs && start) |=> busy);

  generate
    if (DIV >= 2) begin : g_hold
      p_pin_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pins != $past(pins)) |=> (pins == $past(pins)));
    end
  endgenerate

endmodule

// File: tb/id_eeprom_reader_tb.sv
module id_eeprom_reader_tb;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, valid, err;
  logic [1:0]  status;
  logic [63:0] id_words;
  logic        ee_cs, ee_sck, ee_mosi, ee_miso;

  always #5 clk = ~clk;

  id_eeprom_reader #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .valid(valid), .err(err), .status(status), .id_words(id_words),
    .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_mosi(ee_mosi), .ee_miso(ee_miso)
  );

  // Behavioural EEPROM: counts rising clocks, records command, answers pattern
  int          edges = 0;
  logic [8:0]  cmd_seen = '0;
  logic [63:0] pat = '0;
  logic        force_dummy = 1'b0;

  always @(posedge ee_cs) begin
    edges    = 0;
    cmd_seen = '0;
  end

  always @(posedge ee_sck) begin
    if (ee_cs) begin
      edges = edges + 1;
      if (edges <= 9) cmd_seen = {cmd_seen[7:0], ee_mosi};
    end
  end

  assign ee_miso = (edges == 10) ? force_dummy :
                   (edges >= 11 && edges <= 74) ? pat[74 - edges] : 1'b1;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Pin monitors for R2 and R7
  logic [2:0] prev_pins = '0;
  int since = 0;
  bit seen_change = 0;
  int hold_viol = 0;
  int sel_viol = 0;
  int done_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ({ee_cs, ee_sck, ee_mosi} != prev_pins) begin
        if (seen_change && since < DIV) hold_viol++;
        if (ee_cs && !prev_pins[2] && (ee_sck || ee_mosi)) sel_viol++;
        seen_change = 1;
        since = 1;
      end else begin
        since++;
      end
      if (ee_sck && !ee_cs) sel_viol++;
      if (done) done_cnt++;
      prev_pins = {ee_cs, ee_sck, ee_mosi};
    end
  end

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin
        ok = 1;
        break;
      end
    end
    if (!ok) chk(0, "watchdog wait_done", 0, 1);
  endtask

  localparam logic [63:0] PATS [3] = '{
    64'h0012_3456_789A_C0DE,
    64'hFFFF_0000_A5A5_8001,
    64'h8000_0001_7FFE_5AA5
  };

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!ee_cs && !ee_sck && !ee_mosi && !busy && !done, "R1 pins idle in reset",
        {ee_cs, ee_sck, ee_mosi, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && !err && status == 2'b00, "R1 flags after reset", {valid, err, status}, 0);
    chk(id_words == 64'h0, "R1 words zero after reset", id_words, 0);

    // Vector table walk: R3, R5, R6, R8
    for (int v = 0; v < 3; v++) begin
      pat = PATS[v];
      force_dummy = 1'b0;
      pulse_start();
      chk(busy, "R9 busy after start", busy, 1);
      wait_done(ok);
      chk(cmd_seen == 9'b110000000, "R3 command bits", cmd_seen, 9'b110000000);
      chk(edges == 74, "R6 rising edge count", edges, 74);
      chk(valid && !err && status == 2'b01, "R6 valid status", {valid, err, status}, 4'b1001);
      chk(id_words == PATS[v], "R5 received words", id_words, PATS[v]);
      chk(!ee_cs && !ee_sck && !ee_mosi, "R6 pins low at done",
          {ee_cs, ee_sck, ee_mosi}, 0);
      @(negedge clk);
      chk(!busy && !done, "R9 busy drops after done", {busy, done}, 0);
    end

    // R4: forced high leading bit
    pat = 64'hDEAD_BEEF_0BAD_F00D;
    force_dummy = 1'b1;
    pulse_start();
    chk(!valid && !err, "R10 flags cleared at start", {valid, err}, 0);
    wait_done(ok);
    chk(edges == 10, "R4 abort after dummy edge", edges, 10);
    chk(err && !valid && status == 2'b10, "R4 error status", {valid, err, status}, 4'b0110);
    chk(id_words == 64'h0, "R8 words withheld on error", id_words, 0);
    chk(!ee_cs && !ee_sck && !ee_mosi, "R4 pins low after abort",
        {ee_cs, ee_sck, ee_mosi}, 0);
    repeat (DIV * 3) @(negedge clk);
    chk(edges == 10 && !busy, "R4 no further clocking", edges, 10);

    // R9 / R10: start while busy, including at the end step
    pat = 64'h1357_9BDF_2468_ACE0;
    force_dummy = 1'b0;
    done_cnt = 0;
    pulse_start();
    chk(!err && status == 2'b00, "R10 error cleared at new start", {err, status}, 0);
    repeat (300) @(negedge clk);
    pulse_start();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (u_dut.ee_cs == 1'b0 && busy) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        break;
      end
    end
    repeat (DIV * 4) @(negedge clk);
    chk(edges == 74, "R9 restart ignored edge count", edges, 74);
    chk(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
    chk(id_words == pat && valid, "R9 words intact", id_words, pat);
    chk(!busy && !ee_cs, "R9 idle after ignored starts", {busy, ee_cs}, 0);

    chk(hold_viol == 0, "R7 output hold time", hold_viol, 0);
    chk(sel_viol == 0, "R2 select order", sel_viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule